// File: doc/BRIEF.md
# Serial Link-Request Receiver

This block sits on the PHY side of a PHY/link interface. It watches a one-wire request line from the link-layer controller, one sample per clock. A 1 seen while idle is taken as a start bit. The block then shifts in a frame, decodes a 3-bit request type from the three bits that follow the start bit, and works out from that type how long the frame is. All fields are sent most significant bit first.

A completed frame does one of the following:
- A register access becomes a one-cycle read or write strobe on a register-file port.
- An acceleration-control frame loads an enable flag.
- A fair, priority or isochronous bus request loads a pending slot that an arbiter reads.

The block also applies the cancel rules. Whenever the interface control lines show the receive state, fair and priority requests are dropped. An isochronous request survives until the arbiter reports that the bus was won for it. A request whose speed code is not supported is still queued. It is marked, so that winning the bus for it produces a null-packet indication instead of a data transfer.

Top module: `lreq_rx`

## Requirements
- R1: After reset, both strobes are low, the acceleration flag is 0, no slot is pending, all bad-speed flags are 0 and the null-packet indication is low.
- R2: A 9-bit frame with type 100 (start, type, a 4-bit address in bits 4-7, stop in bit 8) gives one single-cycle read strobe, with that address, one clock after the edge that samples the stop bit.
- R3: A 17-bit frame with type 101 (4-bit address in bits 4-7, 8 data bits in bits 8-15, stop in bit 16) gives one single-cycle write strobe, with that address and data, on the same timing as R2. The read and write strobes are never high together.
- R4: A 6-bit frame with type 110 loads the acceleration flag from bit 4, one clock after the stop-bit edge. No other event changes that flag.
- R5: An 8-bit bus-request frame (type 001 fair, 010 priority, 011 isochronous; 3-bit speed in bits 4-6; stop in bit 7) sets the matching pending bit (index 0 fair, 1 priority, 2 isochronous) and stores its speed, one clock after the stop-bit edge.
- R6: A frame whose stop bit is 1 has no effect. The decoder hunts for a new start bit on the very next cycle.
- R7: At every clock edge where the control input equals 10 (receive), the pending fair and priority requests are cleared. The isochronous request is kept.
- R8: A fair or priority frame is discarded if the receive state was sampled on any cycle from its start bit through its stop bit.
- R9: A pending isochronous request is cleared only by a win report that selects it (select code 11). Select codes 01 and 10 choose fair and priority.
- R10: A speed above SPEED_MAX (default 3) still sets the pending bit, and also sets that slot's bad-speed flag. A win for such a slot pulses the null-packet output for one cycle, right after the win edge.
- R11: Type 111 is abandoned after bit 3, and the decoder hunts again on the next cycle. Type 000 is consumed as an 8-bit frame and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_i | input | 1 | Serial request line from the link layer |
| ctl_i | input | 2 | Interface control state; 10 means receive |
| arb_won_i | input | 1 | Arbiter reports a bus win this cycle |
| arb_sel_i | input | 2 | Which request won: 01 fair, 10 priority, 11 isochronous |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| accel_en_o | output | 1 | Arbitration acceleration enable |
| pend_o | output | 3 | Pending requests: bit 0 fair, 1 priority, 2 isochronous |
| pend_speed_o | output | 3*SPD_W | Stored speed for each slot, slot g at bits g*SPD_W |
| pend_bad_o | output | 3 | Speed code of each slot is unsupported |
| null_pkt_o | output | 1 | Bus won for a bad-speed request: send a null packet |

## Verification
Every frame result is due exactly one clock after the edge that samples the stop bit. Reset, RX clears and wins take effect at the edge that samples them.

The driver changes inputs on falling edges. It records the cycle count at the stop-bit edge and pushes each expected strobe, tagged with its due cycle, into a queue. The monitor pops an item at the falling edge where a strobe appears and compares the cycle count as well as the address and data. A strobe that arrives early or late, or one that nothing expected, is therefore reported.

Flag and pending checks are sampled at the falling edge after the due edge. Where the timing matters, the old value is also checked one cycle earlier.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  typedef enum logic [2:0] {
    TY_NONE = 3'b000,
    TY_FAIR = 3'b001,
    TY_PRI  = 3'b010,
    TY_ISO  = 3'b011,
    TY_RD   = 3'b100,
    TY_WR   = 3'b101,
    TY_ACC  = 3'b110,
    TY_BAD  = 3'b111
  } lreq_ty_e;

  localparam logic [1:0] CTL_RX = 2'b10;
  localparam int N_SLOT = 3;
  localparam int TYP_LAST = 3;
endpackage

// File: rtl/lreq_deser.sv
module lreq_deser
  import lreq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SPD_W  = 3,
  localparam int RD_LAST  = TYP_LAST + 1 + ADDR_W,
  localparam int WR_LAST  = TYP_LAST + 1 + ADDR_W + DATA_W,
  localparam int ACC_LAST = TYP_LAST + 2,
  localparam int BUS_LAST = TYP_LAST + 1 + SPD_W,
  localparam int SR_W     = WR_LAST - 1,
  localparam int CNT_W    = $clog2(WR_LAST + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_i,
  input  logic            rx_i,
  output logic            ev_valid_o,
  output lreq_ty_e        ev_ty_o,
  output logic [SR_W-1:0] ev_data_o,
  output logic            ev_rx_o
);
  typedef enum logic {S_HUNT, S_BODY} st_e;

  st_e             st;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  sr;
  lreq_ty_e         ty_q;
  lreq_ty_e         ty_now;
  logic             rx_seen;
  logic [CNT_W-1:0] last_idx;

  assign ty_now = lreq_ty_e'({sr[1:0], ser_i});

  // frame length follows the decoded type
  always_comb begin
    case (ty_q)
      TY_RD:   last_idx = CNT_W'(RD_LAST);
      TY_WR:   last_idx = CNT_W'(WR_LAST);
      TY_ACC:  last_idx = CNT_W'(ACC_LAST);
      TY_BAD:  last_idx = '1;
      default: last_idx = CNT_W'(BUS_LAST);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_HUNT;
      cnt        <= '0;
      sr         <= '0;
      ty_q       <= TY_NONE;
      rx_seen    <= 1'b0;
      ev_valid_o <= 1'b0;
      ev_ty_o    <= TY_NONE;
      ev_data_o  <= '0;
      ev_rx_o    <= 1'b0;
    end else begin
      ev_valid_o <= 1'b0;
      case (st)
        S_HUNT: begin
          if (ser_i) begin
            st      <= S_BODY;
            cnt     <= CNT_W'(1);
            sr      <= '0;
            rx_seen <= rx_i;
          end
        end
        default: begin
          cnt     <= cnt + 1'b1;
          sr      <= {sr[SR_W-2:0], ser_i};
          rx_seen <= rx_seen | rx_i;
          if (cnt == CNT_W'(TYP_LAST)) begin
            ty_q <= ty_now;
            if (ty_now == TY_BAD) st <= S_HUNT;
          end else if (cnt > CNT_W'(TYP_LAST) && cnt == last_idx) begin
            st <= S_HUNT;
            if (!ser_i) begin
              ev_valid_o <= 1'b1;
              ev_ty_o    <= ty_q;
              ev_data_o  <= sr;
              ev_rx_o    <= rx_seen | rx_i;
            end
          end
        end
      endcase
    end
  end

  // R6: a stop bit of 1 never yields a frame event
  p_stop_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BODY && cnt > CNT_W'(TYP_LAST) && cnt == last_idx && ser_i) |=> !ev_valid_o);
endmodule

// File: rtl/lreq_slot.sv
module lreq_slot #(
  parameter int         SPD_W       = 3,
  parameter int         SPEED_MAX   = 3,
  parameter bit         CLEAR_ON_RX = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [SPD_W-1:0] spd_i,
  input  logic             rx_i,
  input  logic             win_i,
  output logic             pend_o,
  output logic [SPD_W-1:0] spd_o,
  output logic             bad_o,
  output logic             null_o
);
  logic clr_rx;
  assign clr_rx = CLEAR_ON_RX && rx_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      spd_o  <= '0;
      bad_o  <= 1'b0;
      null_o <= 1'b0;
    end else begin
      null_o <= win_i && pend_o && bad_o;
      if (clr_rx) begin
        pend_o <= 1'b0;
      end else if (set_i) begin
        pend_o <= 1'b1;
        spd_o  <= spd_i;
        bad_o  <= (int'(spd_i) > SPEED_MAX);
      end else if (win_i) begin
        pend_o <= 1'b0;
      end
    end
  end

  generate
    if (CLEAR_ON_RX) begin : g_rx
      // R7: receive state empties the slot at that edge
      p_rx_clear_r7: assert property (@(posedge clk) disable iff (rst)
        rx_i |=> !pend_o);
    end else begin : g_iso
      // R9: only a win removes this request
      p_iso_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_o && !win_i) |=> pend_o);
    end
  endgenerate
endmodule

// File: rtl/lreq_rx.sv
module lreq_rx
  import lreq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SPD_W     = 3,
  parameter int SPEED_MAX = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lreq_i,
  input  logic [1:0]              ctl_i,
  input  logic                    arb_won_i,
  input  logic [1:0]              arb_sel_i,
  output logic                    reg_rd_o,
  output logic                    reg_wr_o,
  output logic [ADDR_W-1:0]       reg_addr_o,
  output logic [DATA_W-1:0]       reg_wdata_o,
  output logic                    accel_en_o,
  output logic [N_SLOT-1:0]       pend_o,
  output logic [N_SLOT*SPD_W-1:0] pend_speed_o,
  output logic [N_SLOT-1:0]       pend_bad_o,
  output logic                    null_pkt_o
);
  localparam int SR_W = TYP_LAST + ADDR_W + DATA_W;

  logic            rx;
  logic            ev_valid;
  lreq_ty_e        ev_ty;
  logic [SR_W-1:0] ev_data;
  logic            ev_rx;
  logic [N_SLOT-1:0] slot_set;
  logic [N_SLOT-1:0] slot_win;
  logic [N_SLOT-1:0] slot_null;

  assign rx = (ctl_i == CTL_RX);

  lreq_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W)) deser_i (
    .clk(clk), .rst(rst), .ser_i(lreq_i), .rx_i(rx),
    .ev_valid_o(ev_valid), .ev_ty_o(ev_ty), .ev_data_o(ev_data), .ev_rx_o(ev_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      accel_en_o  <= 1'b0;
    end else begin
      reg_rd_o <= ev_valid && ev_ty == TY_RD;
      reg_wr_o <= ev_valid && ev_ty == TY_WR;
      if (ev_valid && ev_ty == TY_RD) reg_addr_o <= ev_data[ADDR_W-1:0];
      if (ev_valid && ev_ty == TY_WR) begin
        reg_addr_o  <= ev_data[DATA_W +: ADDR_W];
        reg_wdata_o <= ev_data[DATA_W-1:0];
      end
      if (ev_valid && ev_ty == TY_ACC) accel_en_o <= ev_data[0];
    end
  end

  always_comb begin
    slot_set[0] = ev_valid && ev_ty == TY_FAIR && !ev_rx;
    slot_set[1] = ev_valid && ev_ty == TY_PRI  && !ev_rx;
    slot_set[2] = ev_valid && ev_ty == TY_ISO;
  end

  genvar g;
  generate
    for (g = 0; g < N_SLOT; g++) begin : g_slot
      assign slot_win[g] = arb_won_i && (arb_sel_i == 2'(g + 1));
      lreq_slot #(
        .SPD_W(SPD_W), .SPEED_MAX(SPEED_MAX), .CLEAR_ON_RX(g < 2)
      ) slot_i (
        .clk(clk), .rst(rst), .set_i(slot_set[g]), .spd_i(ev_data[SPD_W-1:0]),
        .rx_i(rx), .win_i(slot_win[g]), .pend_o(pend_o[g]),
        .spd_o(pend_speed_o[g*SPD_W +: SPD_W]), .bad_o(pend_bad_o[g]),
        .null_o(slot_null[g])
      );
    end
  endgenerate

  assign null_pkt_o = |slot_null;

  // R3: the two register strobes are exclusive
  p_rw_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_o && reg_wr_o));
  // R2: a read strobe lasts a single cycle
  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rd_o |=> !reg_rd_o);
  // R4: only an acceleration frame moves the flag
  p_accel_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_ty == TY_ACC) |=> $stable(accel_en_o));
  // R10: a null packet always follows a win
  p_null_win_r10: assert property (@(posedge clk) disable iff (rst)
    null_pkt_o |-> $past(arb_won_i));
endmodule

// File: tb/lreq_rx_tb_top.sv
module lreq_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lreq = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic       won = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       rd, wr, accel, nullp;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [2:0] pend, bad;
  logic [8:0] spd;

  int     tests = 0;
  int     fails = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  typedef struct {
    int         kind;
    logic [3:0] a;
    logic [7:0] d;
    longint     due;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lreq_rx dut_i (
    .clk(clk), .rst(rst), .lreq_i(lreq), .ctl_i(ctl), .arb_won_i(won),
    .arb_sel_i(sel), .reg_rd_o(rd), .reg_wr_o(wr), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .accel_en_o(accel), .pend_o(pend),
    .pend_speed_o(spd), .pend_bad_o(bad), .null_pkt_o(nullp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives start, type, body (MSB first), stop; rx_bit marks a receive-state cycle
  task automatic send_frame(input logic [2:0] ty, input logic [15:0] body, input int nb,
                            input logic stop, input int rx_bit, output longint stop_cyc);
    for (int i = 0; i < nb + 5; i++) begin
      logic b;
      if (i == 0) b = 1'b1;
      else if (i < 4) b = ty[3 - i];
      else if (i < 4 + nb) b = body[nb - 1 - (i - 4)];
      else b = stop;
      @(negedge clk);
      lreq = b;
      ctl  = (i == rx_bit) ? 2'b10 : 2'b00;
    end
    @(negedge clk);
    lreq = 1'b0;
    ctl  = 2'b00;
    stop_cyc = cyc;
  endtask

  task automatic win(input logic [1:0] s);
    @(negedge clk);
    won = 1'b1;
    sel = s;
    @(negedge clk);
    won = 1'b0;
    sel = 2'b00;
  endtask

  // scoreboard monitor for register strobes
  always @(negedge clk) begin
    if (!rst && (rd || wr)) begin
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2/R3 unexpected strobe actual=rd%0d wr%0d expected=none", rd, wr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if ((e.kind == 0) != rd || (e.kind == 1) != wr || e.a != addr ||
            (e.kind == 1 && e.d != wdata) || e.due != cyc) begin
          fails++;
          $display("FAIL R2/R3 strobe actual=k%0d a%0h d%0h c%0d expected=k%0d a%0h d%0h c%0d",
                   wr, addr, wdata, cyc, e.kind, e.a, e.d, e.due);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    longint sc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd && !wr && !accel && pend == 0 && bad == 0 && !nullp, "R1 reset state",
        {rd, wr, accel, nullp}, 0);

    // R2 read
    send_frame(3'b100, 16'hA, 4, 1'b0, -1, sc);
    sb.push_back('{0, 4'hA, 8'h00, sc + 1});
    // R3 write, then a read straight behind
    send_frame(3'b101, {4'h5, 8'h3C}, 12, 1'b0, -1, sc);
    sb.push_back('{1, 4'h5, 8'h3C, sc + 1});
    send_frame(3'b100, 16'h3, 4, 1'b0, -1, sc);
    sb.push_back('{0, 4'h3, 8'h00, sc + 1});
    send_frame(3'b101, {4'hF, 8'hA5}, 12, 1'b0, -1, sc);
    sb.push_back('{1, 4'hF, 8'hA5, sc + 1});

    // R4 acceleration
    send_frame(3'b110, 16'h1, 1, 1'b0, -1, sc);
    chk(accel == 1'b0, "R4 flag not early", accel, 0);
    @(negedge clk);
    chk(accel == 1'b1, "R4 enable", accel, 1);

    // R5 bus requests
    send_frame(3'b001, 16'h2, 3, 1'b0, -1, sc);
    @(negedge clk);
    chk(pend == 3'b001 && spd[2:0] == 3'd2, "R5 fair", {pend, spd[2:0]}, {3'b001, 3'd2});
    send_frame(3'b010, 16'h1, 3, 1'b0, -1, sc);
    send_frame(3'b011, 16'h3, 3, 1'b0, -1, sc);
    @(negedge clk);
    chk(pend == 3'b111 && spd[5:3] == 3'd1 && spd[8:6] == 3'd3 && bad == 0,
        "R5 pri+iso", {pend, spd[5:3], spd[8:6]}, {3'b111, 3'd1, 3'd3});

    // R7 receive state clears fair and priority only
    @(negedge clk);
    ctl = 2'b10;
    @(negedge clk);
    ctl = 2'b00;
    chk(pend == 3'b100, "R7 rx clear", pend, 3'b100);

    // R8 receive during shifting discards fair and priority
    send_frame(3'b001, 16'h1, 3, 1'b0, 2, sc);
    @(negedge clk);
    chk(pend == 3'b100, "R8 fair discarded", pend, 3'b100);
    send_frame(3'b010, 16'h1, 3, 1'b0, 7, sc);
    @(negedge clk);
    chk(pend == 3'b100, "R8 pri rx on stop", pend, 3'b100);

    // R9 isochronous cleared only by its own win
    win(2'b01);
    chk(pend[2] == 1'b1 && !nullp, "R9 other win keeps iso", pend, 3'b100);
    win(2'b11);
    chk(pend == 3'b000 && !nullp, "R9 iso win clears", {pend, nullp}, 0);

    // R10 unsupported speed
    send_frame(3'b010, 16'h6, 3, 1'b0, -1, sc);
    @(negedge clk);
    chk(pend == 3'b010 && bad == 3'b010 && spd[5:3] == 3'd6, "R10 bad speed queued",
        {pend, bad}, {3'b010, 3'b010});
    win(2'b10);
    chk(nullp == 1'b1 && pend == 3'b000, "R10 null pulse", {nullp, pend}, 4'b1000);
    @(negedge clk);
    chk(nullp == 1'b0, "R10 null single cycle", nullp, 0);

    // R6 bad stop bit
    send_frame(3'b101, {4'h3, 8'h55}, 12, 1'b1, -1, sc);
    @(negedge clk);
    chk(wr == 1'b0, "R6 write dropped", wr, 0);
    send_frame(3'b110, 16'h0, 1, 1'b1, -1, sc);
    @(negedge clk);
    chk(accel == 1'b1, "R6 accel kept", accel, 1);
    send_frame(3'b100, 16'h2, 4, 1'b0, -1, sc);
    sb.push_back('{0, 4'h2, 8'h00, sc + 1});
    @(negedge clk);

    // R11 type 111 abandoned, then a read right after
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lreq = 1'b1;
    end
    send_frame(3'b100, 16'h9, 4, 1'b0, -1, sc);
    sb.push_back('{0, 4'h9, 8'h00, sc + 1});
    send_frame(3'b000, 16'h1, 3, 1'b0, -1, sc);
    @(negedge clk);
    chk(pend == 3'b000 && accel == 1'b1, "R11 type 000 no effect", pend, 0);

    send_frame(3'b110, 16'h0, 1, 1'b0, -1, sc);
    @(negedge clk);
    chk(accel == 1'b0, "R4 disable", accel, 0);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R2 R3 all strobes seen", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule